// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block tells an SDRAM controller when an auto-refresh is owed and runs the clock-enable sequence for self refresh. An interval timer counts clock cycles. Each time it expires, one refresh becomes owed. The interval is the retention period (64 ms) divided by the number of refreshes it needs (4096), converted to clock cycles and rounded down. At the default 50 MHz clock this is 781 cycles. Owed refreshes collect in a pending counter. They are offered to the command arbiter through `ref_req`. The arbiter grants a refresh only when all four banks are idle. After an accepted grant, all commands are held off for the refresh cycle time.

Self refresh is requested with `sr_req`. The scheduler first drains every pending refresh and waits until the banks are idle and no guard time is running. It then spends one cycle in the entry state, where `cke` falls and `sr_entry` marks the entry command. The interval timer stays frozen for the whole self-refresh episode. When `sr_exit` is seen, `cke` rises, the pending count is cleared, and commands stay blocked for the refresh cycle time before normal running resumes.

States and transitions:
- ST_RUN goes to ST_DRAIN when `sr_req` is high.
- ST_DRAIN goes back to ST_RUN when `sr_req` drops. It goes to ST_ENTER when all of these hold: the count is zero, the banks are idle, no guard time is running, and the interval does not expire that cycle.
- ST_ENTER always goes to ST_SELF after one cycle.
- ST_SELF goes to ST_WAKE when `sr_exit` is high.
- ST_WAKE goes to ST_RUN after TRRC_CYC cycles.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the outputs are: `ref_req`=0, `ref_urgent`=0, `cke`=1, `cmd_block`=0, `sr_entry`=0 and `pend_cnt`=0.
- R2: While running (ST_RUN or ST_DRAIN), the pending count rises by one every INTERVAL = RETENTION_US*CLK_MHZ/REFRESH_COUNT cycles (781 by default). The first rise comes INTERVAL cycles after reset is released.
- R3: `ref_req` is high exactly when the state is ST_RUN or ST_DRAIN and `pend_cnt` is nonzero.
- R4: `pend_cnt` never exceeds MAX_POSTPONE (8). An expiry that finds it full is dropped. `ref_urgent` is high exactly when `ref_req` is high and the count equals MAX_POSTPONE.
- R5: A grant is accepted when `ref_grant`, `ref_req` and `banks_idle` are all high and `cmd_block` is low. An accepted grant lowers the count by one on the next cycle. If an interval expiry falls in the same cycle, the count is left unchanged.
- R6: A grant is ignored (no change to the count, no guard time) when `ref_req` is low, when `banks_idle` is low, or when `cmd_block` is high.
- R7: After an accepted grant, `cmd_block` is high for exactly TRRC_CYC cycles (4 by default).
- R8: Self refresh entry is a single ST_ENTER cycle. In that cycle `sr_entry`=1, `cke`=0 and `pend_cnt`=0.
- R9: In ST_SELF, `cke`=0 and `cmd_block`=1, and the interval timer is frozen, so the count stays at zero however long the state lasts.
- R10: When `sr_exit` is seen in ST_SELF, `cke` returns to 1 on the next cycle. `cmd_block` then stays high for exactly TRRC_CYC cycles, the count is zero, and the interval timer resumes from its frozen value.
- R11: If `sr_req` drops while in ST_DRAIN, the block returns to ST_RUN without entering self refresh, and `cke` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter issues the refresh this cycle |
| banks_idle | input | 1 | All four banks are precharged |
| sr_req | input | 1 | Level request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Postponement limit reached |
| cke | output | 1 | Clock enable to the device |
| cmd_block | output | 1 | No command may be issued |
| sr_entry | output | 1 | Issue the self-refresh entry command now |
| pend_cnt | output | clog2(MAX_POSTPONE+1) | Number of owed refreshes |

## Verification
Every output comes from a register, so each response appears one clock edge after the input that causes it. Examples are the count change after a grant, the first `cmd_block` cycle, the `cke` rise after `sr_exit`, and the count rise after an expiry edge. The bench keeps a cycle model that is updated on the same rising edge as the design. It compares all outputs on the falling edge, after that edge has settled, and drives new inputs at the same falling edge. The directed grant checks are placed at a known phase of the interval, so no expiry falls inside the window that is checked. Guard lengths are checked by sampling on each of the TRRC_CYC cycles and on the cycle after them.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_ENTER = 3'd2,
        ST_SELF  = 3'd3,
        ST_WAKE  = 3'd4
    } rfs_state_e;

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // Expiry fires only in cycles where the timer is allowed to advance.
    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int MAX_POSTPONE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clear,
    output logic [$clog2(MAX_POSTPONE+1)-1:0] count
);
    localparam int PW = $clog2(MAX_POSTPONE + 1);
    localparam logic [PW-1:0] FULL = PW'(MAX_POSTPONE);

    logic [PW-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/rfs_guard_timer.sv
module rfs_guard_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic ending
);
    localparam int GC = (CYCLES < 1) ? 1 : CYCLES;
    localparam int GW = $clog2(GC + 1);
    localparam logic [GW-1:0] START = GW'(GC);

    logic [GW-1:0] cnt_q;

    assign busy   = (cnt_q != '0);
    assign ending = (cnt_q <= GW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdr_refresh_pkg::*;
#(
    parameter int CLK_MHZ       = 50,
    parameter int RETENTION_US  = 64000,
    parameter int REFRESH_COUNT = 4096,
    parameter int TRRC_CYC      = 4,
    parameter int MAX_POSTPONE  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    input  logic banks_idle,
    input  logic sr_req,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_urgent,
    output logic cke,
    output logic cmd_block,
    output logic sr_entry,
    output logic [$clog2(MAX_POSTPONE+1)-1:0] pend_cnt
);
    localparam int INTERVAL = (RETENTION_US * CLK_MHZ) / REFRESH_COUNT;
    localparam int PW       = $clog2(MAX_POSTPONE + 1);
    localparam logic [PW-1:0] FULL = PW'(MAX_POSTPONE);

    rfs_state_e state_q, state_d;

    logic          timer_run;
    logic          tick;
    logic          grant_ok;
    logic          wake_start;
    logic          guard_busy;
    logic          guard_ending;
    logic [PW-1:0] pend;

    assign timer_run  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign grant_ok   = ref_grant && ref_req && banks_idle && !cmd_block;
    assign wake_start = (state_q == ST_SELF) && sr_exit;

    rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    rfs_pending_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (grant_ok),
        .clear (wake_start),
        .count (pend)
    );

    rfs_guard_timer #(.CYCLES(TRRC_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (grant_ok || wake_start),
        .busy   (guard_busy),
        .ending (guard_ending)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sr_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!sr_req)
                    state_d = ST_RUN;
                else if ((pend == '0) && banks_idle && !guard_busy && !tick)
                    state_d = ST_ENTER;
            end
            ST_ENTER: state_d = ST_SELF;
            ST_SELF: begin
                if (sr_exit) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (guard_ending) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs, all taken from registered state
    always_comb begin
        ref_req    = 1'b0;
        cke        = 1'b1;
        cmd_block  = guard_busy;
        sr_entry   = 1'b0;
        unique case (state_q)
            ST_RUN, ST_DRAIN: ref_req = (pend != '0);
            ST_ENTER: begin
                cke       = 1'b0;
                cmd_block = 1'b1;
                sr_entry  = 1'b1;
            end
            ST_SELF: begin
                cke       = 1'b0;
                cmd_block = 1'b1;
            end
            ST_WAKE:  cmd_block = 1'b1;
            default: ;
        endcase
        ref_urgent = ref_req && (pend == FULL);
        pend_cnt   = pend;
    end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
    parameter int MAX_POSTPONE = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ref_grant,
    input logic banks_idle,
    input logic ref_req,
    input logic ref_urgent,
    input logic cke,
    input logic cmd_block,
    input logic sr_entry,
    input logic [$clog2(MAX_POSTPONE+1)-1:0] pend_cnt
);
    AST_URGENT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= MAX_POSTPONE); // R4
    AST_REQ_MEANS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (pend_cnt != 0)); // R3
    AST_GRANT_GUARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && ref_req && banks_idle && !cmd_block) |=> cmd_block); // R7
    AST_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        sr_entry |-> (!cke && pend_cnt == 0)); // R8
    AST_ENTRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_entry |=> (!sr_entry && !cke)); // R8
    AST_CKE_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd_block); // R9
    AST_WAKE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_block && pend_cnt == 0)); // R10
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.MAX_POSTPONE(MAX_POSTPONE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_grant  (ref_grant),
    .banks_idle (banks_idle),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .cke        (cke),
    .cmd_block  (cmd_block),
    .sr_entry   (sr_entry),
    .pend_cnt   (pend_cnt)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
    localparam int CLK_MHZ  = 50;
    localparam int INTERVAL = (64000 * CLK_MHZ) / 4096;
    localparam int TRRC     = 4;
    localparam int MAXP     = 8;
    localparam int PW       = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_grant = 1'b0, banks_idle = 1'b1, sr_req = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_urgent, cke, cmd_block, sr_entry;
    logic [PW-1:0] pend_cnt;

    int n_checks = 0, n_errors = 0, cyc = 0, edges = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // Reference model (state: 0 run, 1 drain, 2 enter, 3 self, 4 wake)
    int m_st, m_tmr, m_pend, m_grd;

    always #10 clk = ~clk;   // 50 MHz

    sdram_refresh_sched #(.CLK_MHZ(CLK_MHZ), .TRRC_CYC(TRRC), .MAX_POSTPONE(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
        .sr_req(sr_req), .sr_exit(sr_exit), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .cke(cke), .cmd_block(cmd_block), .sr_entry(sr_entry), .pend_cnt(pend_cnt)
    );

    function automatic bit f_run(int st);      return st == 0 || st == 1; endfunction
    function automatic bit f_req(int st, int p); return f_run(st) && p != 0; endfunction
    function automatic bit f_blk(int st, int g); return g != 0 || st >= 2; endfunction
    function automatic bit f_cke(int st);      return !(st == 2 || st == 3); endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_pend = 0; m_grd = 0; edges = 0;
        end else begin
            bit run, tick, gok, wake;
            int nst, ntmr, npend, ngrd;
            edges++;
            run  = f_run(m_st);
            tick = run && (m_tmr == INTERVAL - 1);
            gok  = ref_grant && f_req(m_st, m_pend) && banks_idle && !f_blk(m_st, m_grd);
            wake = (m_st == 3) && sr_exit;
            ntmr = run ? (tick ? 0 : m_tmr + 1) : m_tmr;
            npend = m_pend;
            if (wake) npend = 0;
            else if (tick && !gok && m_pend < MAXP) npend = m_pend + 1;
            else if (gok && !tick && m_pend > 0) npend = m_pend - 1;
            ngrd = (gok || wake) ? TRRC : (m_grd > 0 ? m_grd - 1 : 0);
            nst = m_st;
            case (m_st)
                0: if (sr_req) nst = 1;
                1: if (!sr_req) nst = 0;
                   else if (m_pend == 0 && banks_idle && m_grd == 0 && !tick) nst = 2;
                2: nst = 3;
                3: if (sr_exit) nst = 4;
                4: if (m_grd <= 1) nst = 0;
                default: nst = 0;
            endcase
            m_st = nst; m_tmr = ntmr; m_pend = npend; m_grd = ngrd;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("R2", "pend_cnt", int'(pend_cnt), m_pend);
            check("R3", "ref_req", int'(ref_req), int'(f_req(m_st, m_pend)));
            check("R4", "ref_urgent", int'(ref_urgent), int'(f_req(m_st, m_pend) && m_pend == MAXP));
            check("R8", "cke", int'(cke), int'(f_cke(m_st)));
            check("R7", "cmd_block", int'(cmd_block), int'(f_blk(m_st, m_grd)));
            check("R8", "sr_entry", int'(sr_entry), int'(m_st == 2));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            finish_run();
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        bit saw_entry;
        int guard;
        void'($urandom(32'd20240611));
        cycles(3);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R1: reset state
        check("R1", "ref_req", ref_req, 0);
        check("R1", "ref_urgent", ref_urgent, 0);
        check("R1", "cke", cke, 1);
        check("R1", "cmd_block", cmd_block, 0);
        check("R1", "sr_entry", sr_entry, 0);
        check("R1", "pend_cnt", pend_cnt, 0);

        // R2: first expiry lands exactly INTERVAL edges after release
        cycles(INTERVAL - 1);
        check("R2", "pend before interval", pend_cnt, 0);
        cycles(1);
        check("R2", "pend at interval", pend_cnt, 1);
        check("R3", "ref_req with one owed", ref_req, 1);

        // R4: saturation with no grants
        cycles(INTERVAL * MAXP + 50);
        check("R4", "pend saturated", pend_cnt, MAXP);
        check("R4", "urgent at limit", ref_urgent, 1);

        // Move to a phase with no expiry for the next few hundred cycles
        while ((edges % INTERVAL) != 100) @(negedge clk);

        // R6: grant ignored with banks busy
        ref_grant = 1'b1; banks_idle = 1'b0;
        cycles(1);
        check("R6", "pend, banks busy", pend_cnt, MAXP);
        check("R6", "no guard, banks busy", cmd_block, 0);
        // R5 / R7: accepted grant
        banks_idle = 1'b1;
        cycles(1);
        check("R5", "pend after grant", pend_cnt, MAXP - 1);
        // R6: grant held during the guard is ignored
        for (int i = 1; i <= TRRC; i++) begin
            check("R7", "guard active", cmd_block, 1);
            if (i < TRRC) ref_grant = 1'b1; else ref_grant = 1'b0;
            cycles(1);
        end
        check("R7", "guard over", cmd_block, 0);
        check("R6", "pend unchanged during guard", pend_cnt, MAXP - 1);

        // R8: drain then enter self refresh
        sr_req = 1'b1; ref_grant = 1'b1; banks_idle = 1'b1;
        guard = 0;
        while (!sr_entry && guard < 2000) begin cycles(1); guard++; end
        check("R8", "entry reached", sr_entry, 1);
        check("R8", "cke low at entry", cke, 0);
        check("R8", "drained at entry", pend_cnt, 0);
        sr_req = 1'b0; ref_grant = 1'b0;

        // R9: frozen timer during a long self refresh
        cycles(INTERVAL * 3);
        check("R9", "pend stays zero", pend_cnt, 0);
        check("R9", "cke held low", cke, 0);
        check("R9", "commands blocked", cmd_block, 1);

        // R10: exit with guard
        sr_exit = 1'b1;
        cycles(1);
        sr_exit = 1'b0;
        check("R10", "cke high after exit", cke, 1);
        for (int i = 1; i <= TRRC; i++) begin
            check("R10", "wake guard", cmd_block, 1);
            cycles(1);
        end
        check("R10", "wake guard over", cmd_block, 0);
        check("R10", "pend cleared", pend_cnt, 0);

        // R11: request withdrawn during drain
        banks_idle = 1'b0; sr_req = 1'b1; saw_entry = 1'b0;
        for (int i = 0; i < 4; i++) begin cycles(1); saw_entry |= sr_entry; end
        sr_req = 1'b0;
        for (int i = 0; i < 3; i++) begin cycles(1); saw_entry |= sr_entry; end
        check("R11", "no entry on withdraw", saw_entry, 0);
        check("R11", "cke stays high", cke, 1);
        banks_idle = 1'b1;

        // Constrained random phase
        for (int i = 0; i < 40000; i++) begin
            ref_grant  = ($urandom % 3) != 0;
            banks_idle = ($urandom % 4) != 0;
            if (($urandom % 1000) < 2) sr_req = ~sr_req;
            sr_exit    = ($urandom % 300) == 0;
            cycles(1);
        end
        sr_req = 1'b0; sr_exit = 1'b0; ref_grant = 1'b0;
        cycles(2);
        finish_run();
    end
endmodule